// File: doc/BRIEF.md
# XGMII Loopback Switch

This block sits on the 64-bit XGMII path between a 10G Ethernet MAC and its PHY, on a single clock. In normal operation it passes MAC transmit words to the PHY and PHY receive words to the MAC. For test it can turn traffic around in one of two ways.

Line loopback sends the PHY's receive stream back out on the PHY transmit side. The same stream still goes on to the MAC, and the MAC's transmit words are dropped. MAC loopback sends the MAC's transmit stream back into the MAC receive side. The PHY then sees idle, and the PHY receive stream is dropped.

Two one-bit enables select the mode. They sit in a small word-addressed register space that is reached over a memory-mapped port with a wait handshake. Every XGMII output is registered, so latency is the same in all modes. A mode change applies as soon as the write lands, with no regard for frame boundaries.

Top module: `xgmii_loop_switch`

## Requirements
- R1: After reset both enables read 0 and the block is in pass-through: MAC TX data/control appear on PHY TX and PHY RX data/control appear on MAC RX. While reset is held, both output sides show idle (data byte 0x07 in every lane, all control bits 1).
- R2: With line loopback enabled, PHY TX carries the PHY RX data and control.
- R3: With line loopback enabled and MAC loopback disabled, MAC RX still carries the PHY RX data and control, and MAC TX data has no effect on either output side.
- R4: With MAC loopback enabled, MAC RX carries the MAC TX data and control.
- R5: With only MAC loopback enabled, PHY TX carries idle (byte 0x07 in each of the 8 lanes, control 0xFF), and PHY RX data has no effect on either output side.
- R6: With both enables set, PHY TX follows PHY RX and MAC RX follows MAC TX.
- R7: Each XGMII output shows the value selected from the inputs present at one rising edge, starting from that edge, in every mode.
- R8: Byte address 0x0 holds the line loopback enable and byte address 0x8 holds the MAC loopback enable. Writes load bit 0 of the write data and ignore the other bits. Reads return the enable in bit 0 and zero in bits 31:1.
- R9: A write to byte address 0x4, or to any unmapped address (0xC), changes neither enable. Reads of those addresses return 0.
- R10: A mode written at a rising edge governs the outputs from the following rising edge onward. The data captured at the edge of the write itself still uses the old mode.
- R11: A read holds the wait signal high in its first cycle. In the next cycle the wait signal is low and the read data is valid. Writes never raise the wait signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | XGMII and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mac_txd | input | 64 | Transmit data from the MAC |
| mac_txc | input | 8 | Transmit control from the MAC |
| mac_rxd | output | 64 | Receive data to the MAC |
| mac_rxc | output | 8 | Receive control to the MAC |
| phy_rxd | input | 64 | Receive data from the PHY |
| phy_rxc | input | 8 | Receive control from the PHY |
| phy_txd | output | 64 | Transmit data to the PHY |
| phy_txc | output | 8 | Transmit control to the PHY |
| cfg_addr | input | 4 | Register byte address |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read request |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| cfg_waitreq | output | 1 | Read wait; high while read data is not ready |

## Verification
The hardest case to reach from the ports is a mode switch in the middle of a stream. Here the word captured at the same edge as the register write must still take the old route, and the next word must take the new one. The bench reaches it by driving a fresh data word on both sides in the same cycle as the write. It then checks two consecutive output words against the old and new routes. To show that dropped inputs really are dropped, the bench runs each mode with distinct patterns on all four input buses. It also reads both enables back after writes that carry junk in the upper bits and after writes to the reserved address.

// File: rtl/xls_pkg.sv
package xls_pkg;
    localparam logic [7:0] IDLE_CHAR = 8'h07;
    localparam int         REG_W     = 32;
    localparam int         WORD_LINE = 0;
    localparam int         WORD_RSVD = 1;
    localparam int         WORD_MAC  = 2;
endpackage

// File: rtl/xls_regs.sv
module xls_regs #(
    parameter int ADDR_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         cfg_addr,
    input  logic                      cfg_wr,
    input  logic                      cfg_rd,
    input  logic [xls_pkg::REG_W-1:0] cfg_wdata,
    output logic [xls_pkg::REG_W-1:0] cfg_rdata,
    output logic                      cfg_waitreq,
    output logic                      line_lb,
    output logic                      mac_lb
);
    import xls_pkg::*;
    localparam int WORD_W = ADDR_W - 2;

    typedef struct packed {
        logic             line_en;
        logic             mac_en;
        logic             ack;
        logic [REG_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;
    logic [WORD_W-1:0] word;
    logic              rd_first;

    assign word     = cfg_addr[ADDR_W-1:2];
    assign rd_first = cfg_rd && !r_q.ack;

    always_comb begin
        r_d     = r_q;
        r_d.ack = rd_first;
        if (cfg_wr) begin
            if (word == WORD_W'(WORD_LINE)) r_d.line_en = cfg_wdata[0];
            if (word == WORD_W'(WORD_MAC))  r_d.mac_en  = cfg_wdata[0];
        end
        if (rd_first) begin
            if (word == WORD_W'(WORD_LINE))     r_d.rdata = REG_W'(r_q.line_en);
            else if (word == WORD_W'(WORD_MAC)) r_d.rdata = REG_W'(r_q.mac_en);
            else                                r_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cfg_rdata   = r_q.rdata;
    assign cfg_waitreq = rd_first;
    assign line_lb     = r_q.line_en;
    assign mac_lb      = r_q.mac_en;

    // R9: the reserved word leaves both enables untouched
    assert_rsvd_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && word == WORD_W'(WORD_RSVD)) |=> ($stable(line_lb) && $stable(mac_lb)));
    // R11: the second cycle of a held read is never stalled
    assert_read_wait_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_waitreq) |=> (!cfg_rd || !cfg_waitreq));
    // R11: writes alone never stall
    assert_write_nowait_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_rd) |-> !cfg_waitreq);
endmodule

// File: rtl/xls_path.sv
module xls_path #(
    parameter int LANES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_lb,
    input  logic                 mac_lb,
    input  logic [8*LANES-1:0]   mac_txd,
    input  logic [LANES-1:0]     mac_txc,
    input  logic [8*LANES-1:0]   phy_rxd,
    input  logic [LANES-1:0]     phy_rxc,
    output logic [8*LANES-1:0]   mac_rxd,
    output logic [LANES-1:0]     mac_rxc,
    output logic [8*LANES-1:0]   phy_txd,
    output logic [LANES-1:0]     phy_txc
);
    import xls_pkg::*;
    localparam int DW = 8 * LANES;

    typedef struct packed {
        logic [DW-1:0]    ptxd;
        logic [LANES-1:0] ptxc;
        logic [DW-1:0]    mrxd;
        logic [LANES-1:0] mrxc;
    } path_t;

    logic [DW-1:0] idle_word;
    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_idle
            assign idle_word[8*g +: 8] = IDLE_CHAR;
        end
    endgenerate

    path_t p_d, p_q;

    always_comb begin
        if (line_lb) begin
            p_d.ptxd = phy_rxd;
            p_d.ptxc = phy_rxc;
        end else if (mac_lb) begin
            p_d.ptxd = idle_word;
            p_d.ptxc = '1;
        end else begin
            p_d.ptxd = mac_txd;
            p_d.ptxc = mac_txc;
        end
        if (mac_lb) begin
            p_d.mrxd = mac_txd;
            p_d.mrxc = mac_txc;
        end else begin
            p_d.mrxd = phy_rxd;
            p_d.mrxc = phy_rxc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q.ptxd <= idle_word;
            p_q.ptxc <= '1;
            p_q.mrxd <= idle_word;
            p_q.mrxc <= '1;
        end else begin
            p_q <= p_d;
        end
    end

    assign phy_txd = p_q.ptxd;
    assign phy_txc = p_q.ptxc;
    assign mac_rxd = p_q.mrxd;
    assign mac_rxc = p_q.mrxc;

    // R2: line loopback turns PHY RX around one edge later
    assert_line_turn_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(line_lb)) |-> (phy_txd == $past(phy_rxd) && phy_txc == $past(phy_rxc)));
    // R3: MAC RX keeps seeing the PHY while MAC loopback is off
    assert_mac_rx_feed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(mac_lb)) |-> (mac_rxd == $past(phy_rxd) && mac_rxc == $past(phy_rxc)));
    // R4: MAC loopback returns MAC TX one edge later
    assert_mac_turn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mac_lb)) |-> (mac_rxd == $past(mac_txd) && mac_rxc == $past(mac_txc)));
    // R5: MAC-only loopback idles the PHY side
    assert_phy_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mac_lb) && !$past(line_lb)) |-> (phy_txd == idle_word && phy_txc == '1));
    // R1: pass-through toward the PHY when no loopback is set
    assert_pass_tx_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(mac_lb) && !$past(line_lb)) |-> (phy_txd == $past(mac_txd) && phy_txc == $past(mac_txc)));
endmodule

// File: rtl/xgmii_loop_switch.sv
module xgmii_loop_switch #(
    parameter int LANES  = 8,
    parameter int ADDR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [8*LANES-1:0]   mac_txd,
    input  logic [LANES-1:0]     mac_txc,
    output logic [8*LANES-1:0]   mac_rxd,
    output logic [LANES-1:0]     mac_rxc,
    input  logic [8*LANES-1:0]   phy_rxd,
    input  logic [LANES-1:0]     phy_rxc,
    output logic [8*LANES-1:0]   phy_txd,
    output logic [LANES-1:0]     phy_txc,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic                 cfg_wr,
    input  logic                 cfg_rd,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    output logic                 cfg_waitreq
);
    logic line_lb;
    logic mac_lb;

    xls_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_addr   (cfg_addr),
        .cfg_wr     (cfg_wr),
        .cfg_rd     (cfg_rd),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .cfg_waitreq(cfg_waitreq),
        .line_lb    (line_lb),
        .mac_lb     (mac_lb)
    );

    xls_path #(.LANES(LANES)) path_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_lb(line_lb),
        .mac_lb (mac_lb),
        .mac_txd(mac_txd),
        .mac_txc(mac_txc),
        .phy_rxd(phy_rxd),
        .phy_rxc(phy_rxc),
        .mac_rxd(mac_rxd),
        .mac_rxc(mac_rxc),
        .phy_txd(phy_txd),
        .phy_txc(phy_txc)
    );
endmodule

// File: tb/xgmii_loop_switch_tb.sv
module xgmii_loop_switch_tb_top;
    localparam int CLK_P = 10;
    localparam logic [71:0] IDLE72 = {8'hFF, {8{8'h07}}};

    logic        clk = 0;
    logic        rst_n = 0;
    logic [63:0] mac_txd = '0, phy_rxd = '0;
    logic [7:0]  mac_txc = '0, phy_rxc = '0;
    logic [63:0] mac_rxd, phy_txd;
    logic [7:0]  mac_rxc, phy_txc;
    logic [3:0]  cfg_addr = '0;
    logic        cfg_wr = 0, cfg_rd = 0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_waitreq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    xgmii_loop_switch dut_i (
        .clk(clk), .rst_n(rst_n),
        .mac_txd(mac_txd), .mac_txc(mac_txc), .mac_rxd(mac_rxd), .mac_rxc(mac_rxc),
        .phy_rxd(phy_rxd), .phy_rxc(phy_rxc), .phy_txd(phy_txd), .phy_txc(phy_txc),
        .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_waitreq(cfg_waitreq)
    );

    // tx source: 0 = MAC TX, 1 = PHY RX, 2 = idle; rx source: 0 = PHY RX, 1 = MAC TX
    typedef struct packed {
        logic        line;
        logic        maclb;
        logic [63:0] mtxd;
        logic [7:0]  mtxc;
        logic [63:0] prxd;
        logic [7:0]  prxc;
        logic [1:0]  tx_src;
        logic        rx_src;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b0, 1'b0, 64'h1111_2222_3333_4444, 8'h01, 64'hAAAA_BBBB_CCCC_DDDD, 8'h80, 2'd0, 1'b0},
        '{1'b0, 1'b0, 64'hDEAD_BEEF_0000_FFFF, 8'h00, 64'h0123_4567_89AB_CDEF, 8'hF0, 2'd0, 1'b0},
        '{1'b1, 1'b0, 64'h5555_5555_5555_5555, 8'h3C, 64'h9999_8888_7777_6666, 8'h0F, 2'd1, 1'b0},
        '{1'b1, 1'b0, 64'hFEDC_BA98_7654_3210, 8'hC3, 64'h0707_0707_0707_07FB, 8'hFF, 2'd1, 1'b0},
        '{1'b0, 1'b1, 64'h0F0F_0F0F_F0F0_F0F0, 8'h5A, 64'h1357_9BDF_2468_ACE0, 8'hA5, 2'd2, 1'b1},
        '{1'b0, 1'b1, 64'hCAFE_F00D_1234_5678, 8'h00, 64'h0000_0000_0000_0001, 8'h11, 2'd2, 1'b1},
        '{1'b1, 1'b1, 64'hAB00_CD00_EF00_1200, 8'h22, 64'h00AB_00CD_00EF_0012, 8'h44, 2'd1, 1'b1},
        '{1'b1, 1'b1, 64'h8000_0000_0000_0001, 8'h81, 64'h7FFF_FFFF_FFFF_FFFE, 8'h7E, 2'd1, 1'b1}
    };

    task automatic check(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d; cfg_wr = 1;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d, output bit wait_first);
        @(negedge clk);
        cfg_addr = a; cfg_rd = 1;
        #1 wait_first = cfg_waitreq;
        @(negedge clk);
        while (cfg_waitreq) @(negedge clk);
        d = cfg_rdata;
        cfg_rd = 0;
    endtask

    function automatic logic [71:0] exp_tx(input vec_t v);
        case (v.tx_src)
            2'd0:    return {v.mtxc, v.mtxd};
            2'd1:    return {v.prxc, v.prxd};
            default: return IDLE72;
        endcase
    endfunction

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        bit          wf;
        logic [71:0] t;

        // R1: idle on both sides while reset is held
        #(CLK_P*2 + 2);
        check({phy_txc, phy_txd} == IDLE72, "R1 reset phy tx", {phy_txc, phy_txd}, IDLE72);
        check({mac_rxc, mac_rxd} == IDLE72, "R1 reset mac rx", {mac_rxc, mac_rxd}, IDLE72);
        @(negedge clk); rst_n = 1;

        reg_read(4'h0, rd, wf);
        check(rd == 0, "R1 line enable after reset", 72'(rd), 72'd0);
        check(wf == 1'b1, "R11 wait high on first read cycle", 72'(wf), 72'd1);
        reg_read(4'h8, rd, wf);
        check(rd == 0, "R1 mac enable after reset", 72'(rd), 72'd0);

        // vector walk: R1 R2 R3 R4 R5 R6 R7
        for (int i = 0; i < 8; i++) begin
            reg_write(4'h0, {31'h0, VEC[i].line});
            reg_write(4'h8, {31'h0, VEC[i].maclb});
            @(negedge clk);
            mac_txd = VEC[i].mtxd; mac_txc = VEC[i].mtxc;
            phy_rxd = VEC[i].prxd; phy_rxc = VEC[i].prxc;
            @(negedge clk);
            t = exp_tx(VEC[i]);
            check({phy_txc, phy_txd} == t, "R2/R5/R6/R7 phy tx vector", {phy_txc, phy_txd}, t);
            t = VEC[i].rx_src ? {VEC[i].mtxc, VEC[i].mtxd} : {VEC[i].prxc, VEC[i].prxd};
            check({mac_rxc, mac_rxd} == t, "R3/R4/R6/R7 mac rx vector", {mac_rxc, mac_rxd}, t);
        end

        // R8: upper write bits ignored, readback bit 0 only
        reg_write(4'h0, 32'hFFFF_FFFE);
        reg_read(4'h0, rd, wf);
        check(rd == 32'h0, "R8 line bit0 clear", 72'(rd), 72'd0);
        reg_write(4'h0, 32'hFFFF_FFFF);
        reg_read(4'h0, rd, wf);
        check(rd == 32'h1, "R8 line readback", 72'(rd), 72'd1);
        reg_write(4'h8, 32'h8000_0003);
        reg_read(4'h8, rd, wf);
        check(rd == 32'h1, "R8 mac readback", 72'(rd), 72'd1);

        // R9: reserved and unmapped writes change nothing
        reg_write(4'h0, 32'h0);
        reg_write(4'h4, 32'hFFFF_FFFF);
        reg_write(4'hC, 32'hFFFF_FFFF);
        reg_read(4'h4, rd, wf);
        check(rd == 0, "R9 reserved reads zero", 72'(rd), 72'd0);
        reg_read(4'hC, rd, wf);
        check(rd == 0, "R9 unmapped reads zero", 72'(rd), 72'd0);
        reg_read(4'h0, rd, wf);
        check(rd == 0, "R9 line unchanged", 72'(rd), 72'd0);
        reg_read(4'h8, rd, wf);
        check(rd == 1, "R9 mac unchanged", 72'(rd), 72'd1);

        // R11: a plain write does not raise wait
        @(negedge clk);
        cfg_addr = 4'h8; cfg_wdata = 32'h0; cfg_wr = 1;
        #1 check(cfg_waitreq == 0, "R11 no wait on write", 72'(cfg_waitreq), 72'd0);
        @(negedge clk); cfg_wr = 0;

        // R10: switch pass-through -> line loopback mid-stream
        @(negedge clk);
        mac_txd = 64'hA1A1_A1A1_A1A1_A1A1; mac_txc = 8'h00;
        phy_rxd = 64'hB2B2_B2B2_B2B2_B2B2; phy_rxc = 8'h01;
        cfg_addr = 4'h0; cfg_wdata = 32'h1; cfg_wr = 1;
        @(negedge clk);
        cfg_wr = 0;
        check(phy_txd == 64'hA1A1_A1A1_A1A1_A1A1, "R10 write-edge word uses old mode",
              {phy_txc, phy_txd}, {8'h00, 64'hA1A1_A1A1_A1A1_A1A1});
        mac_txd = 64'hC3C3_C3C3_C3C3_C3C3;
        phy_rxd = 64'hD4D4_D4D4_D4D4_D4D4;
        @(negedge clk);
        check(phy_txd == 64'hD4D4_D4D4_D4D4_D4D4 && phy_txc == 8'h01, "R10 next word uses new mode",
              {phy_txc, phy_txd}, {8'h01, 64'hD4D4_D4D4_D4D4_D4D4});
        check(mac_rxd == 64'hD4D4_D4D4_D4D4_D4D4, "R3 mac rx still fed in line mode",
              {mac_rxc, mac_rxd}, {8'h01, 64'hD4D4_D4D4_D4D4_D4D4});

        // R7: output holds until the next edge after an input change
        mac_txd = 64'h0;
        phy_rxd = 64'hE5E5_E5E5_E5E5_E5E5;
        #1 check(phy_txd == 64'hD4D4_D4D4_D4D4_D4D4, "R7 output registered",
                 {phy_txc, phy_txd}, {8'h01, 64'hD4D4_D4D4_D4D4_D4D4});

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule